// File: doc/BRIEF.md
# EEPROM page-write sequencer

This block is a synthesizable behavioural model of the write side of a byte-wide parallel EEPROM. The host drives a 15-bit address, an 8-bit write bus and three active-low strobes: chip-select, read-enable and write-enable. A write burst gathers 1 to 64 bytes of one page into a page buffer. Each byte is marked as loaded. The buffer stays open while bytes keep coming. When no new byte has arrived for a set number of cycles, the block starts an internal programming period. At the end of that period, only the marked bytes are copied into the array.

While programming runs, any read returns a status byte instead of array data. The host polls this status to learn when the write has finished. All timing is counted in clock cycles set by parameters.

The array stores 2**STORE_PG_W pages. Page-address bits above that width alias onto the stored pages.

The strobe interface has no back-pressure, because the host owns the timing. The host keeps each strobe asserted for as long as it wants. Bytes offered while programming runs are dropped, and the host is expected to poll the status first.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset, busy and page_err are 0, the read bus is released, and every array byte reads as 8'hFF.
- R2: A write strobe exists only in the cycles where ce_n=0, we_n=0 and oe_n=1. A pulse with oe_n low or ce_n high writes nothing.
- R3: A write strobe held for fewer than MIN_PULSE consecutive cycles is discarded. One held for exactly MIN_PULSE cycles is accepted.
- R4: The byte address is taken in the first cycle of the strobe, and the data is taken in its last cycle.
- R5: Programming begins LOAD_WIN cycles after the end of the last accepted byte of the same page. Each accepted byte restarts this count. The rise of busy is seen between LOAD_WIN and LOAD_WIN+4 cycles after the strobe is released.
- R6: Within one burst, bytes may arrive in any offset order (address bits [5:0]), and a later byte to the same offset replaces the earlier one.
- R7: Only offsets loaded in the burst change in the array. Every other byte of the page keeps its previous value.
- R8: A byte whose page field (address bits [14:6]) differs from the first byte of the burst is dropped. It sets page_err, which stays 1 until reset.
- R9: busy stays high for PROG_CYC cycles, and write strobes during that time change nothing.
- R10: While busy, a read returns bit 7 equal to the inverse of bit 7 of the most recently loaded byte, and bits 5:0 equal to 0. After busy falls, reads return array data.
- R11: While busy, bit 6 of the read data starts at 0 and inverts after each completed read access.
- R12: rdata_en is 1 only when ce_n=0, oe_n=0 and we_n=1. rdata is 0 whenever rdata_en is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 15 | Byte address: page in [14:6], offset in [5:0] |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, or status while busy |
| rdata_en | output | 1 | Read bus driven |
| busy | output | 1 | Programming in progress |
| page_err | output | 1 | Sticky flag for a dropped cross-page byte |

## Verification
The assertions assume that strobes are synchronous to clk and that the host never asserts a write strobe and a read at once. The bench meets this by changing pins only on falling clock edges and by releasing every strobe before starting the next access. The assertions also assume PROG_CYC of at least 2 and at least one accepted byte before programming begins. Both always hold, because the bench uses the default parameters and programming can only start from a loaded burst.

// File: rtl/eeprom_pw_pkg.sv
`timescale 1ns/1ps
package eeprom_pw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } seq_state_t;
endpackage

// File: rtl/eeprom_strobe_filter.sv
`timescale 1ns/1ps
// Turns a level write strobe into one accept pulse per qualifying pulse.
module eeprom_strobe_filter #(
  parameter int ADDR_W    = 15,
  parameter int DATA_W    = 8,
  parameter int MIN_PULSE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              acc_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CW = $clog2(MIN_PULSE + 1);

  logic          strobe_q;
  logic [CW-1:0] width_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      width_q  <= '0;
      acc_o    <= 1'b0;
      addr_o   <= '0;
      data_o   <= '0;
    end else begin
      strobe_q <= strobe_i;
      acc_o    <= !strobe_i && strobe_q && (width_q >= CW'(MIN_PULSE));
      if (strobe_i) begin
        data_o <= data_i;                 // last active cycle wins
        if (!strobe_q) begin
          addr_o  <= addr_i;              // first active cycle
          width_q <= CW'(1);
        end else if (width_q < CW'(MIN_PULSE)) begin
          width_q <= width_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_seq_ctrl.sv
`timescale 1ns/1ps
// Load window, programming timer, page check and status toggle.
module eeprom_seq_ctrl
  import eeprom_pw_pkg::*;
#(
  parameter int PAGE_W     = 9,
  parameter int STORE_PG_W = 3,
  parameter int LOAD_WIN   = 40,
  parameter int PROG_CYC   = 60
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  acc_i,
  input  logic [PAGE_W-1:0]     acc_page_i,
  input  logic                  strobe_i,
  input  logic                  rd_en_i,
  output logic                  buf_we_o,
  output logic                  commit_o,
  output logic [STORE_PG_W-1:0] prog_page_o,
  output logic                  busy_o,
  output logic                  page_err_o,
  output logic                  toggle_o
);
  localparam int TW = $clog2(LOAD_WIN);
  localparam int PW = $clog2(PROG_CYC);

  seq_state_t        st;
  logic [TW-1:0]     win_q;
  logic [PW-1:0]     prog_q;
  logic [PAGE_W-1:0] page_q;
  logic              rd_q;
  logic              same_page;

  assign same_page   = (acc_page_i == page_q);
  assign buf_we_o    = acc_i && ((st == ST_IDLE) || (st == ST_LOAD && same_page));
  assign commit_o    = (st == ST_PROG) && (prog_q == PW'(PROG_CYC - 1));
  assign busy_o      = (st == ST_PROG);
  assign prog_page_o = page_q[STORE_PG_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      win_q      <= '0;
      prog_q     <= '0;
      page_q     <= '0;
      rd_q       <= 1'b0;
      page_err_o <= 1'b0;
      toggle_o   <= 1'b0;
    end else begin
      rd_q <= rd_en_i;
      unique case (st)
        ST_IDLE: if (acc_i) begin
          page_q <= acc_page_i;
          win_q  <= '0;
          st     <= ST_LOAD;
        end
        ST_LOAD: begin
          if (acc_i && !same_page) page_err_o <= 1'b1;
          if (acc_i && same_page) begin
            win_q <= '0;
          end else if (!strobe_i) begin
            if (win_q == TW'(LOAD_WIN - 1)) begin
              st       <= ST_PROG;
              prog_q   <= '0;
              toggle_o <= 1'b0;
            end else begin
              win_q <= win_q + 1'b1;
            end
          end
        end
        ST_PROG: begin
          if (rd_q && !rd_en_i) toggle_o <= ~toggle_o;
          if (commit_o) st <= ST_IDLE;
          else          prog_q <= prog_q + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    page_err_o |=> page_err_o);
  a_r5_prog_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(st == ST_LOAD));
  a_r9_busy_min: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |=> busy_o);
endmodule

// File: rtl/eeprom_page_store.sv
`timescale 1ns/1ps
// Page buffer with per-byte load mask, and the stored array.
module eeprom_page_store #(
  parameter int DATA_W     = 8,
  parameter int OFS_W      = 6,
  parameter int STORE_PG_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        we_i,
  input  logic [OFS_W-1:0]            wr_ofs_i,
  input  logic [DATA_W-1:0]           wr_data_i,
  input  logic                        commit_i,
  input  logic [STORE_PG_W-1:0]       commit_page_i,
  input  logic                        busy_i,
  input  logic [STORE_PG_W+OFS_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0]           rd_data_o,
  output logic                        last_msb_o
);
  localparam int BYTES = 1 << OFS_W;
  localparam int DEPTH = 1 << (STORE_PG_W + OFS_W);

  logic [DATA_W-1:0] pbuf [BYTES];
  logic [BYTES-1:0]  mask_q;
  logic [DATA_W-1:0] mem  [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '0;
      last_msb_o <= 1'b0;
      for (int i = 0; i < BYTES; i++) pbuf[i] <= '0;
      for (int j = 0; j < DEPTH; j++) mem[j] <= '1;
    end else begin
      if (we_i) begin
        pbuf[wr_ofs_i]   <= wr_data_i;
        mask_q[wr_ofs_i] <= 1'b1;
        last_msb_o       <= wr_data_i[DATA_W-1];
      end
      if (commit_i) begin
        for (int i = 0; i < BYTES; i++)
          if (mask_q[i]) mem[{commit_page_i, OFS_W'(i)}] <= pbuf[i];
        mask_q <= '0;
      end
    end
  end

  assign rd_data_o = mem[rd_addr_i];

  a_r7_commit_has_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |-> (mask_q != '0));
  a_r9_load_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && $past(busy_i)) |-> $stable(mask_q));
endmodule

// File: rtl/eeprom_page_writer.sv
`timescale 1ns/1ps
module eeprom_page_writer #(
  parameter int ADDR_W     = 15,
  parameter int DATA_W     = 8,
  parameter int OFS_W      = 6,
  parameter int STORE_PG_W = 3,
  parameter int LOAD_WIN   = 40,
  parameter int PROG_CYC   = 60,
  parameter int MIN_PULSE  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_en,
  output logic              busy,
  output logic              page_err
);
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic                  wr_strobe, rd_en, acc, buf_we, commit, toggle, last_msb;
  logic [ADDR_W-1:0]     acc_addr;
  logic [DATA_W-1:0]     acc_data, mem_rd, status;
  logic [STORE_PG_W-1:0] prog_page;

  assign wr_strobe = ~ce_n & ~we_n & oe_n;
  assign rd_en     = ~ce_n & ~oe_n & we_n;
  assign rdata_en  = rd_en;

  eeprom_strobe_filter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE(MIN_PULSE)) u_filt (
    .clk(clk), .rst_n(rst_n), .strobe_i(wr_strobe), .addr_i(addr), .data_i(wdata),
    .acc_o(acc), .addr_o(acc_addr), .data_o(acc_data));

  eeprom_seq_ctrl #(.PAGE_W(PAGE_W), .STORE_PG_W(STORE_PG_W),
                    .LOAD_WIN(LOAD_WIN), .PROG_CYC(PROG_CYC)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .acc_page_i(acc_addr[ADDR_W-1:OFS_W]),
    .strobe_i(wr_strobe), .rd_en_i(rd_en), .buf_we_o(buf_we), .commit_o(commit),
    .prog_page_o(prog_page), .busy_o(busy), .page_err_o(page_err), .toggle_o(toggle));

  eeprom_page_store #(.DATA_W(DATA_W), .OFS_W(OFS_W), .STORE_PG_W(STORE_PG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we_i(buf_we), .wr_ofs_i(acc_addr[OFS_W-1:0]),
    .wr_data_i(acc_data), .commit_i(commit), .commit_page_i(prog_page), .busy_i(busy),
    .rd_addr_i(addr[STORE_PG_W+OFS_W-1:0]), .rd_data_o(mem_rd), .last_msb_o(last_msb));

  always_comb begin
    status             = '0;
    status[DATA_W-1]   = ~last_msb;
    status[DATA_W-2]   = toggle;
    rdata              = '0;
    if (rd_en) rdata   = busy ? status : mem_rd;
  end

  a_r10_status_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_en) |-> (rdata[DATA_W-3:0] == '0));
endmodule

// File: tb/tb_eeprom_page_writer.sv
`timescale 1ns/1ps
module tb_eeprom_page_writer;
  localparam int LOAD_WIN = 40;
  localparam int PROG_CYC = 60;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [14:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic rdata_en, busy, page_err;
  int checks = 0, errors = 0, busy_cnt = 0;

  always #4 clk = ~clk;

  eeprom_page_writer dut (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rdata_en(rdata_en), .busy(busy),
    .page_err(page_err));

  always @(negedge clk) begin
    #2;
    if (busy) busy_cnt++;
  end

  // {oe_low, ce_high, width[3:0], addr[14:0], data[7:0], expect_written}
  localparam logic [29:0] VEC [7] = '{
    {1'b0, 1'b0, 4'd3, 15'h0040, 8'h5A, 1'b1},
    {1'b1, 1'b0, 4'd3, 15'h0081, 8'h11, 1'b0},
    {1'b0, 1'b1, 4'd3, 15'h00C2, 8'h33, 1'b0},
    {1'b0, 1'b0, 4'd1, 15'h0103, 8'h22, 1'b0},
    {1'b0, 1'b0, 4'd2, 15'h0144, 8'hA5, 1'b1},
    {1'b0, 1'b0, 4'd5, 15'h0185, 8'h00, 1'b1},
    {1'b0, 1'b0, 4'd3, 15'h01C6, 8'h80, 1'b1}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d, input int w,
                    input logic oe_lo, input logic ce_hi);
    @(negedge clk);
    addr = a; wdata = d; ce_n = ce_hi; oe_n = ~oe_lo; we_n = 1'b0;
    repeat (w) @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1; addr = 15'h7FFF; wdata = 8'hEE;
  endtask

  task automatic rd(input logic [14:0] a, output logic [7:0] v, output logic en);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    @(negedge clk);
    v = rdata; en = rdata_en;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_busy(input logic lvl, output int n);
    n = 0;
    while (busy !== lvl && n < 1000) begin @(negedge clk); n++; end
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog R9 actual=stalled expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic en;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 page_err", page_err, 0);
    check("R1 bus released", rdata_en, 0);
    rd(15'h0000, v, en);
    check("R1 erased", v, 8'hFF);
    check("R12 read drives", en, 1);
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 0; #2;
    check("R12 released with we low", {rdata_en, rdata}, 0);
    ce_n = 1; we_n = 1; #2;
    check("R12 released with ce high", {rdata_en, rdata}, 0);
    oe_n = 1;

    // Vector table: single-byte writes to separate pages.
    foreach (VEC[k]) begin
      wr(VEC[k][23:9], VEC[k][8:1], int'(VEC[k][27:24]), VEC[k][29], VEC[k][28]);
      repeat (LOAD_WIN + PROG_CYC + 20) @(negedge clk);
      rd(VEC[k][23:9], v, en);
      check($sformatf("R2/R3 vector %0d", k), v, VEC[k][0] ? VEC[k][8:1] : 8'hFF);
    end

    // Multi-byte burst on page 0.
    wr(15'h000A, 8'h01, 3, 0, 0);
    repeat (LOAD_WIN - 10) @(negedge clk);
    check("R5 window open 1", busy, 0);
    wr(15'h0003, 8'h02, 3, 0, 0);
    repeat (LOAD_WIN - 10) @(negedge clk);
    check("R5 window open 2", busy, 0);
    wr(15'h0045, 8'h99, 3, 0, 0);
    @(negedge clk); @(negedge clk);
    check("R8 err set", page_err, 1);
    wr(15'h000A, 8'h77, 3, 0, 0);
    repeat (LOAD_WIN - 10) @(negedge clk);
    check("R5 window open 3", busy, 0);
    // R4: address from first cycle, data from last cycle.
    @(negedge clk);
    addr = 15'h0005; wdata = 8'h12; ce_n = 0; oe_n = 1; we_n = 0;
    @(negedge clk); addr = 15'h0006;
    @(negedge clk); wdata = 8'h34;
    @(negedge clk);
    we_n = 1; ce_n = 1; addr = 15'h7FFF; wdata = 8'hEE;
    busy_cnt = 0;
    wait_busy(1'b1, n);
    checks++;
    if (n < LOAD_WIN || n > LOAD_WIN + 4) begin
      errors++;
      $display("FAIL R5 busy delay actual=%0d expected=%0d..%0d", n, LOAD_WIN, LOAD_WIN + 4);
    end
    rd(15'h0005, v, en);
    check("R10 status first", v, 8'h80);
    rd(15'h0030, v, en);
    check("R11 status toggled", v, 8'hC0);
    rd(15'h0005, v, en);
    check("R11 status toggled back", v, 8'h80);
    wr(15'h0020, 8'h42, 3, 0, 0);
    wait_busy(1'b0, n);
    checks++;
    if (busy_cnt < PROG_CYC - 1 || busy_cnt > PROG_CYC + 1) begin
      errors++;
      $display("FAIL R9 busy length actual=%0d expected=%0d", busy_cnt, PROG_CYC);
    end
    repeat (LOAD_WIN + 10) @(negedge clk);
    check("R9 no prog after busy write", busy, 0);
    rd(15'h000A, v, en); check("R6 overwrite", v, 8'h77);
    rd(15'h0003, v, en); check("R6 any order", v, 8'h02);
    rd(15'h0005, v, en); check("R4 data last cycle", v, 8'h34);
    rd(15'h0006, v, en); check("R4 addr first cycle", v, 8'hFF);
    rd(15'h0000, v, en); check("R7 untouched", v, 8'hFF);
    rd(15'h0020, v, en); check("R9 busy write dropped", v, 8'hFF);
    rd(15'h0045, v, en); check("R8 cross-page dropped", v, 8'hFF);
    rd(15'h0040, v, en); check("R8 other page intact", v, 8'h5A);

    // Partial page rewrite keeps neighbours.
    wr(15'h01C0, 8'h3C, 3, 0, 0);
    wait_busy(1'b1, n);
    wait_busy(1'b0, n);
    rd(15'h01C0, v, en); check("R7 loaded byte", v, 8'h3C);
    rd(15'h01C6, v, en); check("R7 neighbour kept", v, 8'h80);
    check("R8 sticky", page_err, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule